// File: doc/BRIEF.md
# Folded Multi-Octave Wavelet Decomposition Stage

This block is the back half of a one-dimensional discrete wavelet analysis pipeline. An upstream stage, which is not part of this block, produces a low-band sample stream at no more than one sample every two clocks. This block takes that stream and computes the second octave from it. It also computes every deeper octave on the same single pair of low-pass and high-pass filters, in clock slots that the second octave leaves free.

A free-running binary counter fixes the slot plan. Odd counter values serve octave 2, the value 2 serves octave 3, and the value 0 is an idle slot. Each octave keeps its own window of past samples and its own one-entry input holding register, so the shared filter pair only needs a multiplexer in front of it. Each octave below the last sends its low-band result, rescaled, to the next octave as an input sample. The last octave emits both of its bands. Every coefficient leaves on one shared result port, tagged with its octave number and band.

Top module: `dwt2_fold_stage`

## Requirements
- R1: Each incoming sample is held in a one-entry buffer for octave 2. The source delivers at most one sample every two clocks. Octave 2 consumes its buffer only in a cycle where the 2-bit slot counter is odd. The counter is 0 after reset and advances by one every clock, modulo 4.
- R2: Octave 3 is computed only when the counter equals 2. The value 0 is an idle slot. In every cycle exactly one of the octave-2 slot, the octave-3 slot and the idle slot is active.
- R3: Each octave filters its own input stream x with a 4-tap window that starts as zeros. The filters are low = 4·x[n] + 7·x[n-1] + 2·x[n-2] − 1·x[n-3] and high = −1·x[n] − 2·x[n-1] + 7·x[n-2] − 4·x[n-3]. Both are evaluated only at the 2nd, 4th, 6th, … sample of that stream. Each octave-2 high result is emitted as an 18-bit two's-complement word.
- R4: The octave-2 low result is not emitted. It is arithmetically shifted right by 3 and truncated to an 8-bit two's-complement value, which becomes the next octave-3 input sample.
- R5: Each result carries a 2-bit octave tag, 2 or 3, and a band bit: 0 for high-pass detail, 1 for low-pass approximation. Band 1 appears only with octave 3.
- R6: Results are registered. Let e be the number of clock edges since reset release. An octave-2 high word is visible when e is even. An octave-3 high word is visible when e mod 4 = 3.
- R7: A slot whose octave has no buffered sample produces no output strobe and leaves that octave's window and pair phase unchanged. Input gaps therefore alter no later result, and a quiet input yields no strobes.
- R8: A synchronous active-high reset clears the output strobe, the counter, the buffers and all octave histories.
- R9: For N input samples, with N a multiple of 4, the block emits N/2 octave-2 high words, N/4 octave-3 high words and N/4 octave-3 low words.
- R10: The octave-3 low result is parked and emitted in the next idle slot, visible when e mod 4 = 1. This happens before the next octave-3 result pair is formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe for a low-band sample from the upstream stage |
| in_data | input | 8 | Signed input sample |
| out_valid | output | 1 | Result strobe |
| out_data | output | 18 | Signed filter result |
| out_octave | output | 2 | Octave number of the result (2 or 3) |
| out_band | output | 1 | 0 = high-pass detail, 1 = low-pass approximation |

## Verification
Several rules are checked by assertions on every clock:
- the slot decode stays mutually exclusive;
- an octave's buffer is never overwritten before it is consumed;
- an idle octave's pair phase holds;
- a high word follows a completed pair;
- a low word carries the last-octave tag;
- the parked low result is drained before the next pair completes.

Other behaviour can be shown only by the bench's scenarios, which it compares against an independent arithmetic model:
- the filter values and the rescaled hand-off between octaves;
- the clock phase at which each stream appears;
- the per-stream result counts;
- that input gaps of odd length, a quiet window and a mid-run reset leave later results correct.

// File: rtl/dwt2_pkg.sv
package dwt2_pkg;

    typedef enum logic {
        BAND_HI = 1'b0,
        BAND_LO = 1'b1
    } band_e;

    // Slot owned by bank b (octave b+2): low b+1 counter bits equal 2**b.
    function automatic logic slot_hit(input logic [7:0] cnt, input int b);
        logic [7:0] mask;
        logic [7:0] want;
        mask = 8'((1 << (b + 1)) - 1);
        want = 8'(1 << b);
        return (cnt & mask) == want;
    endfunction

endpackage

// File: rtl/dwt2_slot_ctrl.sv
module dwt2_slot_ctrl #(
    parameter int NB   = 2,
    parameter int CNTW = 2
) (
    input  logic          clk,
    input  logic          rst,
    output logic [NB-1:0] slot,
    output logic          idle
);
    import dwt2_pkg::*;

    logic [CNTW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + CNTW'(1);
    end

    for (genvar b = 0; b < NB; b++) begin : g_slot
        assign slot[b] = slot_hit(8'(cnt), b);
    end

    assign idle = (cnt == '0);

    // R2: exactly one slot kind active per cycle
    assert_one_slot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones({idle, slot}) == 1);

endmodule

// File: rtl/dwt2_octave_bank.sv
module dwt2_octave_bank #(
    parameter int W = 8,
    parameter int L = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                slot,
    input  logic                push_v,
    input  logic signed [W-1:0] push_d,
    output logic                fire,
    output logic                pair_done,
    output logic signed [W-1:0] nwin [L]
);
    logic                pend_v;
    logic signed [W-1:0] pend_d;
    logic signed [W-1:0] win [L];
    logic                phase;

    assign fire      = slot & pend_v;
    assign pair_done = fire & phase;

    always_comb begin
        nwin[0] = pend_d;
        for (int i = 1; i < L; i++) nwin[i] = win[i-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend_d <= '0;
            phase  <= 1'b0;
            for (int i = 0; i < L; i++) win[i] <= '0;
        end else begin
            if (fire) begin
                for (int i = 0; i < L; i++) win[i] <= nwin[i];
                phase <= ~phase;
            end
            if (push_v) begin
                pend_v <= 1'b1;
                pend_d <= push_d;
            end else if (fire) begin
                pend_v <= 1'b0;
            end
        end
    end

    // R1: a new sample never lands on an unconsumed one
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        (push_v && pend_v) |-> fire);

    // R7: a slot without data leaves the pair phase untouched
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(phase));

endmodule

// File: rtl/dwt2_filter_pair.sv
module dwt2_filter_pair #(
    parameter int             W       = 8,
    parameter int             CW      = 8,
    parameter int             L       = 4,
    parameter int             OW      = 18,
    parameter logic [L*CW-1:0] LO_COEF = 32'hFF020704,
    parameter logic [L*CW-1:0] HI_COEF = 32'hFC07FEFF
) (
    input  logic signed [W-1:0]  win [L],
    output logic signed [OW-1:0] lo,
    output logic signed [OW-1:0] hi
);
    always_comb begin
        lo = '0;
        hi = '0;
        for (int i = 0; i < L; i++) begin
            lo = lo + OW'(win[i]) * OW'($signed(LO_COEF[i*CW +: CW]));
            hi = hi + OW'(win[i]) * OW'($signed(HI_COEF[i*CW +: CW]));
        end
    end
endmodule

// File: rtl/dwt2_fold_stage.sv
module dwt2_fold_stage #(
    parameter int              J       = 3,
    parameter int              W       = 8,
    parameter int              CW      = 8,
    parameter int              L       = 4,
    parameter int              FRAC    = 3,
    parameter logic [L*CW-1:0] LO_COEF = 32'hFF020704,
    parameter logic [L*CW-1:0] HI_COEF = 32'hFC07FEFF,
    localparam int             OW      = W + CW + $clog2(L),
    localparam int             OTW     = $clog2(J + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [W-1:0]   in_data,
    output logic           out_valid,
    output logic [OW-1:0]  out_data,
    output logic [OTW-1:0] out_octave,
    output logic           out_band
);
    import dwt2_pkg::*;

    localparam int NB   = J - 1;
    localparam int CNTW = J - 1;

    logic [NB-1:0]       slot, fire, pair_done, push_v;
    logic                idle;
    logic signed [W-1:0] push_d [NB];
    logic signed [W-1:0] nwin_all [NB][L];
    logic signed [W-1:0] sel_win [L];
    logic signed [OW-1:0] lo, hi, held_d;
    logic signed [W-1:0] feed;
    logic                held_v;
    logic [OTW-1:0]      done_oct;

    dwt2_slot_ctrl #(.NB(NB), .CNTW(CNTW)) u_ctrl (
        .clk(clk), .rst(rst), .slot(slot), .idle(idle)
    );

    assign feed = W'(lo >>> FRAC);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        if (b == 0) begin : g_head
            assign push_v[b] = in_valid;
            assign push_d[b] = $signed(in_data);
        end else begin : g_fold
            assign push_v[b] = pair_done[b-1];
            assign push_d[b] = feed;
        end
        dwt2_octave_bank #(.W(W), .L(L)) u_bank (
            .clk(clk), .rst(rst), .slot(slot[b]),
            .push_v(push_v[b]), .push_d(push_d[b]),
            .fire(fire[b]), .pair_done(pair_done[b]),
            .nwin(nwin_all[b])
        );
    end

    always_comb begin
        for (int i = 0; i < L; i++) sel_win[i] = '0;
        done_oct = '0;
        for (int b = 0; b < NB; b++) begin
            if (fire[b]) sel_win = nwin_all[b];
            if (pair_done[b]) done_oct = OTW'(b + 2);
        end
    end

    dwt2_filter_pair #(
        .W(W), .CW(CW), .L(L), .OW(OW),
        .LO_COEF(LO_COEF), .HI_COEF(HI_COEF)
    ) u_filt (
        .win(sel_win), .lo(lo), .hi(hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_octave <= '0;
            out_band   <= BAND_HI;
            held_v     <= 1'b0;
            held_d     <= '0;
        end else begin
            out_valid <= 1'b0;
            if (|pair_done) begin
                out_valid  <= 1'b1;
                out_data   <= hi;
                out_octave <= done_oct;
                out_band   <= BAND_HI;
                if (pair_done[NB-1]) begin
                    held_v <= 1'b1;
                    held_d <= lo;
                end
            end else if (idle && held_v) begin
                out_valid  <= 1'b1;
                out_data   <= held_d;
                out_octave <= OTW'(J);
                out_band   <= BAND_LO;
                held_v     <= 1'b0;
            end
        end
    end

    // R5: approximation words only from the last octave
    assert_low_last_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_band) |-> (out_octave == OTW'(J)));

    // R6: a detail word is always the product of a pair completed one clock earlier
    assert_hi_after_pair_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_band) |-> $past(|pair_done));

    // R10: parked approximation drained before the next last-octave pair
    assert_held_free_R10: assert property (@(posedge clk) disable iff (rst)
        pair_done[NB-1] |-> !held_v);

endmodule

// File: tb/dwt2_fold_stage_tb.sv
module dwt2_fold_stage_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic [17:0] out_data;
    logic [1:0]  out_octave;
    logic        out_band;

    always #4 clk = ~clk;

    dwt2_fold_stage u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data),
        .out_octave(out_octave), .out_band(out_band)
    );

    int n_chk = 0, n_bad = 0;
    int lo_c [4] = '{4, 7, 2, -1};
    int hi_c [4] = '{-1, -2, 7, -4};
    int h2 [4], h3 [4];
    int n2, n3;
    int qh2 [$], qh3 [$], ql3 [$];
    int rx2, rx3h, rx3l, rx_all;
    int e;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin h2[i] = 0; h3[i] = 0; end
        n2 = 0; n3 = 0;
        rx2 = 0; rx3h = 0; rx3l = 0;
    endtask

    task automatic model_oct3(input int x);
        int lo, hi;
        for (int i = 3; i > 0; i--) h3[i] = h3[i-1];
        h3[0] = x; n3++;
        if (n3 % 2 == 0) begin
            lo = 0; hi = 0;
            for (int i = 0; i < 4; i++) begin
                lo += lo_c[i] * h3[i];
                hi += hi_c[i] * h3[i];
            end
            qh3.push_back(hi);
            ql3.push_back(lo);
        end
    endtask

    task automatic model_oct2(input int x);
        int lo, hi;
        logic signed [7:0] t;
        for (int i = 3; i > 0; i--) h2[i] = h2[i-1];
        h2[0] = x; n2++;
        if (n2 % 2 == 0) begin
            lo = 0; hi = 0;
            for (int i = 0; i < 4; i++) begin
                lo += lo_c[i] * h2[i];
                hi += hi_c[i] * h2[i];
            end
            qh2.push_back(hi);
            t = 8'(lo >>> 3);   // R4 hand-off
            model_oct3(int'(t));
        end
    endtask

    // driver: one sample, then gap extra idle clocks
    task automatic send(input int x, input int gap);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'(x);
        model_oct2(x);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (rst) e <= 0;
        else     e <= e + 1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            int act, exp;
            act = int'($signed(out_data));
            rx_all++;
            if (out_octave == 2'd2 && out_band == 1'b0) begin
                rx2++;
                if (qh2.size() == 0) check(0, "R7 unexpected octave-2 word", act, 0);
                else begin
                    exp = qh2.pop_front();
                    check(act == exp, "R3 octave-2 detail", act, exp);
                end
                check(e % 2 == 0, "R6 octave-2 phase", e % 4, 0);
            end else if (out_octave == 2'd3 && out_band == 1'b0) begin
                rx3h++;
                if (qh3.size() == 0) check(0, "R7 unexpected octave-3 detail", act, 0);
                else begin
                    exp = qh3.pop_front();
                    check(act == exp, "R4 octave-3 detail", act, exp);
                end
                check(e % 4 == 3, "R6 octave-3 detail phase", e % 4, 3);
            end else if (out_octave == 2'd3 && out_band == 1'b1) begin
                rx3l++;
                if (ql3.size() == 0) check(0, "R7 unexpected octave-3 approx", act, 0);
                else begin
                    exp = ql3.pop_front();
                    check(act == exp, "R4 octave-3 approx", act, exp);
                end
                check(e % 4 == 1, "R10 octave-3 approx phase", e % 4, 1);
            end else begin
                check(0, "R5 tag", {out_octave, out_band}, 4);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int base, lfsr;
        model_reset();
        rx_all = 0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8 strobe low in reset", out_valid, 0);
        rst = 1'b0;

        // R7: no input, no strobe
        repeat (12) @(negedge clk);
        check(rx_all == 0, "R7 quiet start", rx_all, 0);

        // impulse
        send(100, 0);
        for (int i = 0; i < 7; i++) send(0, 0);
        // ramp with odd gaps shifting the phase against the counter
        for (int i = 0; i < 8; i++) send(i * 15 - 50, (i % 3 == 0) ? 1 : 0);
        // alternating extremes
        for (int i = 0; i < 8; i++) send((i % 2 == 0) ? 127 : -128, 0);
        // pseudo-random with long gaps (R7)
        lfsr = 8'hA5;
        for (int i = 0; i < 8; i++) begin
            lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 8'hFF;
            send(int'($signed(8'(lfsr))), (i == 3) ? 9 : i % 2);
        end
        repeat (24) @(negedge clk);

        // R9: counts for 32 inputs
        check(rx2 == 16, "R9 octave-2 count", rx2, 16);
        check(rx3h == 8, "R9 octave-3 detail count", rx3h, 8);
        check(rx3l == 8, "R9 octave-3 approx count", rx3l, 8);
        check(qh2.size() + qh3.size() + ql3.size() == 0, "R9 all drained",
              qh2.size() + qh3.size() + ql3.size(), 0);

        // R7: quiet window after drain
        base = rx_all;
        repeat (16) @(negedge clk);
        check(rx_all == base, "R7 quiet window", rx_all - base, 0);

        // R8: mid-run reset clears histories; then a step input
        send(90, 0); send(-70, 0);
        @(negedge clk);
        rst = 1'b1;
        qh2.delete(); qh3.delete(); ql3.delete();
        model_reset();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8 strobe low after mid reset", out_valid, 0);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) send(60, i % 2);
        repeat (24) @(negedge clk);
        check(rx2 == 4 && rx3h == 2 && rx3l == 2, "R9 counts after reset",
              rx2 * 100 + rx3h * 10 + rx3l, 422);
        check(qh2.size() + qh3.size() + ql3.size() == 0, "R8 drained after reset",
              qh2.size() + qh3.size() + ql3.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule